// File: doc/BRIEF.md
# 8-bit DDR Memory Bus Host Controller

This block is the host side of a narrow double-data-rate memory bus. A local client hands it a request through a valid/ready handshake. The request carries a 3-bit operation code, a 45-bit address, a 16-bit write word and a read byte count. The controller pulls chip select low and shifts out a 48-bit command/address header, one byte per bus clock edge. After the header it does one of two things. For a write it sends two data bytes. For a read it releases the data bus and collects bytes that the device qualifies with its read strobe. It raises chip select when the transfer is complete.

The block runs on a system clock at twice the bus clock rate, so every system cycle is one bus edge. The bus clock idles low and toggles every cycle while the device is selected. A build parameter chooses whether a complementary clock is also driven.

Request back-pressure: a request is taken only on an edge where `req_valid` and `req_ready` are both high. The request fields are sampled on that edge only. `req_ready` stays low from the transaction until the chip-select-high interval has elapsed.

Read data has no back-pressure. The device cannot be paused, so the client must take `rd_data` on every cycle in which `rd_valid` is high.

A read ends in one of two ways. It ends normally after the requested number of bytes. It ends with an error after a run of strobe-low cycles.

Top module: `ddr8_host_ctrl`

## Requirements
- R1: During and right after reset: `bus_cs_n`=1, `bus_ck`=0, `bus_dq_oe`=0, `req_ready`=1, and `done`, `err`, `rd_valid` are 0. `bus_ck_n`=1 when the clock pair is differential.
- R2: `req_ready` is high only while no transaction is active and the chip-select-high interval has elapsed. A request is accepted on an edge with `req_valid` and `req_ready` both high.
- R3: The header word is `{req_op, req_addr}` (48 bits). In the six cycles that start one cycle after acceptance, `bus_dq_out` carries the header bytes most significant first, with `bus_dq_oe`=1 and `bus_cs_n`=0.
- R4: `bus_ck` is 1 in the first selected cycle and inverts every cycle while `bus_cs_n` stays low. It is 0 whenever `bus_cs_n` is 1.
- R5: With `DIFF_CLK`=1, `bus_ck_n` is always the inverse of `bus_ck`. With `DIFF_CLK`=0, `bus_ck_n` is held at 0.
- R6: A write is a request with `req_op[2]`=0. After the header it drives `req_wdata[15:8]` and then `req_wdata[7:0]` with `bus_dq_oe`=1. `bus_cs_n` rises after exactly eight selected cycles, and `bus_rds` has no effect on any output.
- R7: A read is a request with `req_op[2]`=1. After the header `bus_dq_oe` is 0 until the read ends. `bus_rds` is first sampled on the edge that closes the seventh selected cycle.
- R8: On every sampling edge of a read where `bus_rds` is 1, `rd_valid` is 1 in the following cycle and `rd_data` holds `bus_dq_in` as it was at that edge.
- R9: A read ends on the sampling edge that delivers byte number `req_len`; a length of 0 counts as 1. On that edge `bus_cs_n` rises together with the last `rd_valid`.
- R10: If `bus_rds` is 0 on `TMO_CYCLES` consecutive sampling edges, the read ends: `bus_cs_n` rises and `err` is pulsed.
- R11: `done` is a one-cycle pulse in the first cycle after `bus_cs_n` rises. `err` is high only alongside a `done` that ends a timed-out read.
- R12: Between transactions `bus_cs_n` stays high for at least max(`cfg_cs_gap`, 1) cycles. If a request is waiting, the next transaction starts exactly then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cs_gap | input | GAP_W | Minimum chip-select-high cycles between transactions |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 3 | Operation code; bit 2 = 1 read, 0 write |
| req_addr | input | 45 | Address field of the header |
| req_wdata | input | 16 | Write word, high byte sent first |
| req_len | input | LEN_W | Read byte count (0 treated as 1) |
| rd_valid | output | 1 | Read byte present (no back-pressure) |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Transaction finished pulse |
| err | output | 1 | Read strobe timeout, with done |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_ck | output | 1 | Bus clock |
| bus_ck_n | output | 1 | Complementary bus clock or constant 0 |
| bus_dq_out | output | 8 | Data bus output value |
| bus_dq_oe | output | 1 | Data bus output enable |
| bus_dq_in | input | 8 | Data bus input value |
| bus_rds | input | 1 | Read data strobe from the device |

## Verification
Call the accepting edge E. The first header byte is visible one cycle after E, and header byte k is visible k+1 cycles after E. The write bytes follow in cycles 7 and 8, and chip select rises on edge E+8. On a read, strobe samples start at edge E+7. Each captured byte and the matching `rd_valid` appear one cycle after the edge that sampled them, and `done` appears in the same cycle that chip select is seen high.

The reference model in the bench advances on each rising edge, using the same request and device inputs as the design. Every output is compared at the falling edge that follows, so every result is checked in exactly the cycle it is due. The device model drives the strobe and the data from the count of selected cycles, with chosen latencies and gap patterns. The single-ended instance runs alongside the differential one.

// File: rtl/ddr8_host_pkg.sv
package ddr8_host_pkg;
  localparam int OP_W       = 3;
  localparam int ADDR_W     = 45;
  localparam int HDR_BYTES  = 6;
  localparam int WR_BYTES   = 2;
  localparam int OP_RD_BIT  = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_WDAT,
    ST_RDAT
  } host_st_t;
endpackage

// File: rtl/ddr8_hdr_shift.sv
module ddr8_hdr_shift #(
  parameter int NBYTES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                shift,
  input  logic [8*NBYTES-1:0] din,
  output logic [7:0]          byte_o
);
  localparam int SW = 8 * NBYTES;

  logic [SW-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)        sreg <= '0;
    else if (load)  sreg <= din;
    else if (shift) sreg <= {sreg[SW-9:0], 8'h00};
  end

  assign byte_o = sreg[SW-1 -: 8];
endmodule

// File: rtl/ddr8_ck_gen.sv
module ddr8_ck_gen #(
  parameter bit DIFF_CLK = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  input  logic stop,
  output logic ck,
  output logic ck_n
);
  always_ff @(posedge clk) begin
    if (rst || stop) ck <= 1'b0;
    else if (start)  ck <= 1'b1;
    else if (run)    ck <= ~ck;
  end

  generate
    if (DIFF_CLK) begin : g_pair
      assign ck_n = ~ck;
    end else begin : g_single
      assign ck_n = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ddr8_rd_track.sv
module ddr8_rd_track #(
  parameter int LEN_W      = 8,
  parameter int TMO_CYCLES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample,
  input  logic             rds,
  input  logic [LEN_W-1:0] len,
  output logic             last,
  output logic             tmo
);
  localparam int TMO_W = $clog2(TMO_CYCLES + 1);

  logic [LEN_W-1:0] cnt;
  logic [LEN_W:0]   cnt_nxt;
  logic [TMO_W-1:0] quiet;
  logic [TMO_W-1:0] quiet_nxt;

  assign cnt_nxt   = {1'b0, cnt} + {{LEN_W{1'b0}}, 1'b1};
  assign quiet_nxt = quiet + TMO_W'(1);
  assign last      = sample && rds && (cnt_nxt >= {1'b0, len});
  assign tmo       = sample && !rds && (quiet_nxt == TMO_W'(TMO_CYCLES));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt   <= '0;
      quiet <= '0;
    end else if (sample) begin
      if (rds) begin
        cnt   <= cnt_nxt[LEN_W-1:0];
        quiet <= '0;
      end else if (!tmo) begin
        quiet <= quiet_nxt;
      end else begin
        quiet <= '0;
      end
    end
  end

  AST_QUIET_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    sample |-> (quiet < TMO_W'(TMO_CYCLES))); // R10
endmodule

// File: rtl/ddr8_host_ctrl.sv
module ddr8_host_ctrl
  import ddr8_host_pkg::*;
#(
  parameter bit DIFF_CLK   = 1'b1,
  parameter int LEN_W      = 8,
  parameter int GAP_W      = 4,
  parameter int TMO_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GAP_W-1:0]  cfg_cs_gap,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              err,
  output logic              bus_cs_n,
  output logic              bus_ck,
  output logic              bus_ck_n,
  output logic [7:0]        bus_dq_out,
  output logic              bus_dq_oe,
  input  logic [7:0]        bus_dq_in,
  input  logic              bus_rds
);
  localparam int SH_BYTES = HDR_BYTES + WR_BYTES;
  localparam int POS_W    = $clog2(SH_BYTES);
  localparam logic [POS_W-1:0] POS_HDR_END = POS_W'(HDR_BYTES - 1);
  localparam logic [POS_W-1:0] POS_WR_END  = POS_W'(SH_BYTES - 1);

  host_st_t         st;
  logic [POS_W-1:0] pos;
  logic [GAP_W-1:0] gap;
  logic [LEN_W-1:0] len_q;
  logic             accept;
  logic             fin;
  logic             trk_last;
  logic             trk_tmo;

  assign req_ready = (st == ST_IDLE) && (gap == '0);
  assign accept    = req_valid && req_ready;
  assign fin       = ((st == ST_WDAT) && (pos == POS_WR_END)) ||
                     ((st == ST_RDAT) && (trk_last || trk_tmo));

  ddr8_hdr_shift #(.NBYTES(SH_BYTES)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .shift  (st != ST_IDLE),
    .din    ({req_op, req_addr, req_wdata}),
    .byte_o (bus_dq_out)
  );

  ddr8_ck_gen #(.DIFF_CLK(DIFF_CLK)) u_ck (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .run   (st != ST_IDLE),
    .stop  (fin),
    .ck    (bus_ck),
    .ck_n  (bus_ck_n)
  );

  ddr8_rd_track #(.LEN_W(LEN_W), .TMO_CYCLES(TMO_CYCLES)) u_trk (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .sample (st == ST_RDAT),
    .rds    (bus_rds),
    .len    (len_q),
    .last   (trk_last),
    .tmo    (trk_tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pos       <= '0;
      gap       <= '0;
      len_q     <= '0;
      bus_cs_n  <= 1'b1;
      bus_dq_oe <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (gap != '0) gap <= gap - GAP_W'(1);
          if (accept) begin
            st        <= ST_HDR;
            pos       <= '0;
            len_q     <= req_len;
            bus_cs_n  <= 1'b0;
            bus_dq_oe <= 1'b1;
          end
        end
        ST_HDR: begin
          pos <= pos + POS_W'(1);
          if (pos == POS_HDR_END) begin
            if (req_op_rd_q) begin
              st        <= ST_RDAT;
              bus_dq_oe <= 1'b0;
            end else begin
              st <= ST_WDAT;
            end
          end
        end
        ST_WDAT: pos <= pos + POS_W'(1);
        ST_RDAT: begin
          if (bus_rds) begin
            rd_valid <= 1'b1;
            rd_data  <= bus_dq_in;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (fin) begin
        st        <= ST_IDLE;
        bus_cs_n  <= 1'b1;
        bus_dq_oe <= 1'b0;
        done      <= 1'b1;
        err       <= trk_tmo;
        gap       <= (cfg_cs_gap == '0) ? '0 : cfg_cs_gap - GAP_W'(1);
      end
    end
  end

  logic req_op_rd_q;
  always_ff @(posedge clk) begin
    if (rst)         req_op_rd_q <= 1'b0;
    else if (accept) req_op_rd_q <= req_op[OP_RD_BIT];
  end

  AST_CK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    bus_cs_n |-> !bus_ck); // R4
  AST_CK_TOGGLES_SELECTED: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && !$past(bus_cs_n)) |-> (bus_ck != $past(bus_ck))); // R4
  AST_OE_WITHIN_SELECT: assert property (@(posedge clk) disable iff (rst)
    bus_dq_oe |-> !bus_cs_n); // R7
  AST_RDATA_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !bus_dq_oe); // R8
  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> bus_cs_n); // R2
  AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    done |-> (bus_cs_n && !$past(bus_cs_n))); // R11
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err |-> done); // R11
endmodule

// File: tb/ddr8_host_ctrl_test.sv
module ddr8_host_ctrl_test;
  localparam int LEN_W = 8;
  localparam int GAP_W = 4;
  localparam int TMO   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [GAP_W-1:0] cfg_cs_gap = '0;
  logic             req_valid  = 1'b0;
  logic [2:0]       req_op     = '0;
  logic [44:0]      req_addr   = '0;
  logic [15:0]      req_wdata  = '0;
  logic [LEN_W-1:0] req_len    = '0;
  logic [7:0]       bus_dq_in  = '0;
  logic             bus_rds    = 1'b0;

  logic       req_ready, rd_valid, done, err, bus_cs_n, bus_ck, bus_ck_n, bus_dq_oe;
  logic [7:0] rd_data, bus_dq_out;
  logic       s_ready, s_rv, s_done, s_err, s_cs_n, s_ck, s_ck_n, s_oe;
  logic [7:0] s_rd, s_dq;

  ddr8_host_ctrl #(.DIFF_CLK(1'b1), .LEN_W(LEN_W), .GAP_W(GAP_W), .TMO_CYCLES(TMO)) uut (
    .clk(clk), .rst(rst), .cfg_cs_gap(cfg_cs_gap), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err), .bus_cs_n(bus_cs_n),
    .bus_ck(bus_ck), .bus_ck_n(bus_ck_n), .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe),
    .bus_dq_in(bus_dq_in), .bus_rds(bus_rds));

  ddr8_host_ctrl #(.DIFF_CLK(1'b0), .LEN_W(LEN_W), .GAP_W(GAP_W), .TMO_CYCLES(TMO)) uut_se (
    .clk(clk), .rst(rst), .cfg_cs_gap(cfg_cs_gap), .req_valid(req_valid), .req_ready(s_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .rd_valid(s_rv), .rd_data(s_rd), .done(s_done), .err(s_err), .bus_cs_n(s_cs_n),
    .bus_ck(s_ck), .bus_ck_n(s_ck_n), .bus_dq_out(s_dq), .bus_dq_oe(s_oe),
    .bus_dq_in(bus_dq_in), .bus_rds(bus_rds));

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference model
  bit         m_busy, m_rd;
  int         m_pos, m_gap, m_len, m_cnt, m_quiet;
  logic [47:0] m_hdr;
  logic [15:0] m_wd;
  logic       e_cs_n, e_ck, e_oe, e_rv, e_done, e_err;
  logic [7:0] e_dq, e_rdata;
  bit         m_rdy;

  task automatic end_txn(input bit timed_out);
    m_busy = 0;
    e_cs_n = 1; e_ck = 0; e_oe = 0;
    e_done = 1; e_err = timed_out;
    m_gap  = (cfg_cs_gap == 0) ? 0 : int'(cfg_cs_gap) - 1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_gap = 0; m_pos = 0;
      e_cs_n = 1; e_ck = 0; e_oe = 0; e_rv = 0; e_done = 0; e_err = 0;
      e_dq = 0; e_rdata = 0;
    end else begin
      m_rdy = !m_busy && (m_gap == 0);
      e_rv = 0; e_done = 0; e_err = 0;
      if (!m_busy) begin
        if (m_gap > 0) m_gap--;
        if (req_valid && m_rdy) begin
          m_busy = 1; m_pos = 0;
          m_hdr = {req_op, req_addr}; m_wd = req_wdata; m_rd = req_op[2];
          m_len = (req_len == 0) ? 1 : int'(req_len);
          m_cnt = 0; m_quiet = 0;
          e_cs_n = 0; e_ck = 1; e_oe = 1; e_dq = m_hdr[47:40];
        end
      end else if (m_pos < 5) begin
        m_pos++; e_ck = !e_ck; e_dq = m_hdr[47-8*m_pos -: 8];
      end else if (!m_rd) begin
        if (m_pos == 5)      begin m_pos = 6; e_ck = !e_ck; e_dq = m_wd[15:8]; end
        else if (m_pos == 6) begin m_pos = 7; e_ck = !e_ck; e_dq = m_wd[7:0]; end
        else end_txn(0);
      end else if (m_pos == 5) begin
        m_pos = 6; e_ck = !e_ck; e_oe = 0;
      end else if (bus_rds) begin
        e_rv = 1; e_rdata = bus_dq_in; m_cnt++; m_quiet = 0;
        if (m_cnt >= m_len) end_txn(0); else e_ck = !e_ck;
      end else begin
        m_quiet++;
        if (m_quiet >= TMO) end_txn(1); else e_ck = !e_ck;
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(req_ready == (!m_busy && m_gap == 0), "R2 req_ready", req_ready, !m_busy && m_gap == 0);
      check(bus_cs_n == e_cs_n, m_rd ? "R9 bus_cs_n (read)" : "R12 bus_cs_n", bus_cs_n, e_cs_n);
      check(bus_ck == e_ck, "R4 bus_ck", bus_ck, e_ck);
      check(bus_ck_n == !e_ck, "R5 bus_ck_n differential", bus_ck_n, !e_ck);
      check(s_ck_n == 1'b0, "R5 bus_ck_n single-ended", s_ck_n, 0);
      check(s_ck == e_ck && s_cs_n == e_cs_n, "R5 single-ended timing", {s_ck, s_cs_n}, {e_ck, e_cs_n});
      check(bus_dq_oe == e_oe, "R7 bus_dq_oe", bus_dq_oe, e_oe);
      if (e_oe) check(bus_dq_out == e_dq, (m_pos < 6) ? "R3 header byte" : "R6 write byte", bus_dq_out, e_dq);
      check(rd_valid == e_rv, "R8 rd_valid", rd_valid, e_rv);
      if (e_rv) check(rd_data == e_rdata, "R8 rd_data", rd_data, e_rdata);
      check(done == e_done, "R11 done", done, e_done);
      check(err == e_err, "R10 err", err, e_err);
    end
  end

  // Device model: strobe and data from the count of selected cycles
  int sel_cyc = 0;
  bit force_rds = 0;
  bit dev_rd = 0;
  int dev_lat = 0;
  int dev_gapmod = 0;
  always @(negedge clk) begin
    if (bus_cs_n) sel_cyc = 0; else sel_cyc++;
    bus_dq_in <= 8'($urandom);
    bus_rds   <= force_rds || (dev_rd && sel_cyc >= 7 + dev_lat &&
                 (dev_gapmod == 0 || (sel_cyc % dev_gapmod) != 0));
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic issue(input logic [2:0] op, input logic [44:0] a, input logic [15:0] wd, input logic [7:0] n);
    req_op = op; req_addr = a; req_wdata = wd; req_len = n; req_valid = 1;
    while (!(!m_busy && m_gap == 0)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_end();
    req_valid = 0;
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held and just after release
    check(bus_cs_n == 1 && bus_ck == 0 && bus_ck_n == 1 && bus_dq_oe == 0,
          "R1 bus idle in reset", {bus_cs_n, bus_ck, bus_ck_n, bus_dq_oe}, 4'b1010);
    rst = 0;
    @(negedge clk);
    check(req_ready && !done && !err && !rd_valid && bus_cs_n && !bus_ck,
          "R1 idle after reset", {req_ready, done, err, rd_valid, bus_cs_n, bus_ck}, 6'b100010);
    cfg_cs_gap = 2;

    // R6: write with strobe held high (must be ignored)
    force_rds = 1;
    issue(3'b001, 45'h1A2B_3C4D_5E6F, 16'hA55A, 8'd0);
    wait_end();
    force_rds = 0;

    // R8 R9: read, latency 2, four bytes
    dev_rd = 1; dev_lat = 2; dev_gapmod = 0;
    issue(3'b100, 45'h0F0F_0F0F_0F0F, 16'h0, 8'd4);
    wait_end();

    // R8: read with strobe gaps, seven bytes
    dev_lat = 0; dev_gapmod = 3;
    issue(3'b110, 45'h1555_5555_5555, 16'h0, 8'd7);
    wait_end();

    // R9: zero length counts as one byte
    dev_lat = 1; dev_gapmod = 0;
    issue(3'b101, 45'h0000_0000_0001, 16'h0, 8'd0);
    wait_end();

    // R10: strobe never rises -> timeout with err
    dev_rd = 0;
    issue(3'b100, 45'h1FFF_FFFF_FFFF, 16'h0, 8'd4);
    wait_end();

    // R12: back-to-back requests with a long gap
    cfg_cs_gap = 5; dev_rd = 1; dev_lat = 0;
    issue(3'b000, 45'h0123_4567_89AB, 16'h1234, 8'd0);
    issue(3'b100, 45'h0BA9_8765_4321, 16'h0, 8'd2);
    wait_end();

    // R12: zero gap setting still leaves one high cycle
    cfg_cs_gap = 0;
    issue(3'b011, 45'h0000_FFFF_0000, 16'hBEEF, 8'd0);
    issue(3'b010, 45'h1111_0000_1111, 16'hCAFE, 8'd0);
    wait_end();

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule